// File: doc/BRIEF.md
# Single-Cycle Register-Register Integer Core

This block is a minimal integer core that runs one register-to-register instruction per clock cycle. In each cycle it presents the program counter on a read-only instruction port. The word that comes back is split into its fields, two operands are read from a 32-entry register file, a combinational ALU computes the result, and the result is written back at the next rising edge. The instruction memory sits outside the block and answers in the same cycle.

Only the 32-bit register-register class with major opcode `0110011` is executed. A word with any other opcode, or with an unsupported funct3/funct7 pair, leaves every register unchanged, and the program counter still steps on. A side port can place a value into any register, and a separate debug read port returns any register's contents. Together they let a test environment set operands and check results without immediate-class instructions.

Top module: `rrc_core`

## Requirements
- R1: The instruction address output is 0 while reset is asserted, and it increases by exactly 4 at every rising clock edge after reset, whatever the instruction.
- R2: The word on the instruction input is executed in the cycle it is presented. Its result is in the destination register after the next rising edge, and an instruction in the next cycle that reads that register gets the new value.
- R3: Only words whose bits [6:0] equal `0110011` can write a register. Any other opcode writes nothing.
- R4: Field positions are destination index [11:7], funct3 [14:12], first source index [19:15], second source index [24:20] and funct7 [31:25].
- R5: funct3 `000` with funct7 `0000000` adds, and with funct7 `0100000` subtracts (first minus second). Both wrap modulo 2^32.
- R6: funct3 `010` (signed) and `011` (unsigned), with funct7 `0000000`, write 1 if the first operand is less than the second and 0 otherwise.
- R7: With funct7 `0000000`, funct3 `100` gives XOR, `110` gives OR and `111` gives AND.
- R8: funct3 `001` with funct7 `0000000` shifts left logically. funct3 `101` with funct7 `0000000` shifts right logically, and with funct7 `0100000` shifts right arithmetically. The shift amount is the low 5 bits of the second operand.
- R9: A register-register word whose funct3/funct7 pair is not listed in R5 to R8 writes no register.
- R10: Register 0 always reads as zero. Writes to it, from an instruction or from the side port, are discarded.
- R11: Reset clears every register to zero.
- R12: When the side-port write enable is high, the side-port data goes into the indexed register at the next rising edge. It takes priority over an instruction write to the same register in that cycle.
- R13: The debug read port returns the indexed register's current value combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Byte address of the instruction being fetched |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dbg_idx_i | input | 5 | Debug read register index |
| dbg_data_o | output | 32 | Debug read data |
| seed_we_i | input | 1 | Side-port register write enable |
| seed_idx_i | input | 5 | Side-port register index |
| seed_data_i | input | 32 | Side-port write data |

## Verification
The hardest case to reach is the one in which a write really happens and must be kept out. Results are only observable when registers hold varied nonzero data, and the register-register class alone cannot create such data from a file that reset has cleared. The stimulus therefore fills the registers through the side port while the fetched words are non-register-register opcodes. It then drives words that write x0, words with illegal opcodes, and words with unsupported funct pairs, each aimed at a register that already holds a known value. It also includes one cycle in which an instruction and the side port target the same register at once.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] F7_BASE   = 7'b0000000;
  localparam logic [6:0] F7_ALT    = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
  } alu_op_e;
endpackage

// File: rtl/rrc_pc.sv
module rrc_pc #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_q + XLEN'(STEP);
  end

  assign pc_o = pc_q;

  a_r1_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
endmodule

// File: rtl/rrc_decode.sv
module rrc_decode
  import rrc_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int IDXW = 5
) (
  input  logic [ILEN-1:0] instr_i,
  output logic [IDXW-1:0] rs1_o,
  output logic [IDXW-1:0] rs2_o,
  output logic [IDXW-1:0] rd_o,
  output alu_op_e         op_o,
  output logic            we_o
);
  logic [6:0] opcode;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       legal;

  assign opcode = instr_i[6:0];
  assign rd_o   = instr_i[7 +: IDXW];
  assign f3     = instr_i[14:12];
  assign rs1_o  = instr_i[15 +: IDXW];
  assign rs2_o  = instr_i[20 +: IDXW];
  assign f7     = instr_i[31:25];

  always_comb begin
    op_o  = ALU_ADD;
    legal = 1'b0;
    unique case (f3)
      3'b000: begin
        if (f7 == F7_BASE)     begin op_o = ALU_ADD; legal = 1'b1; end
        else if (f7 == F7_ALT) begin op_o = ALU_SUB; legal = 1'b1; end
      end
      3'b001: if (f7 == F7_BASE) begin op_o = ALU_SLL;  legal = 1'b1; end
      3'b010: if (f7 == F7_BASE) begin op_o = ALU_SLT;  legal = 1'b1; end
      3'b011: if (f7 == F7_BASE) begin op_o = ALU_SLTU; legal = 1'b1; end
      3'b100: if (f7 == F7_BASE) begin op_o = ALU_XOR;  legal = 1'b1; end
      3'b101: begin
        if (f7 == F7_BASE)     begin op_o = ALU_SRL; legal = 1'b1; end
        else if (f7 == F7_ALT) begin op_o = ALU_SRA; legal = 1'b1; end
      end
      3'b110: if (f7 == F7_BASE) begin op_o = ALU_OR;  legal = 1'b1; end
      3'b111: if (f7 == F7_BASE) begin op_o = ALU_AND; legal = 1'b1; end
      default: ;
    endcase
  end

  assign we_o = (opcode == OPC_REG) && legal;

  // R9: only the two funct7 encodings ever reach a write
  always_comb begin
    if (we_o) a_r9_f7_legal: assert (instr_i[31] == 1'b0 && instr_i[29:25] == 5'b0);
  end
endmodule

// File: rtl/rrc_regfile.sv
module rrc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] ra_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [IDXW-1:0] rb_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic [IDXW-1:0] dbg_i,
  output logic [XLEN-1:0] dbg_data_o,
  input  logic            we_i,
  input  logic [IDXW-1:0] wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic            seed_we_i,
  input  logic [IDXW-1:0] seed_idx_i,
  input  logic [XLEN-1:0] seed_data_i
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (seed_we_i && seed_idx_i == IDXW'(i))  regs_q[i] <= seed_data_i;
        else if (we_i && wa_i == IDXW'(i))        regs_q[i] <= wd_i;
      end
    end
  end

  assign ra_data_o  = (ra_i  == '0) ? '0 : regs_q[ra_i];
  assign rb_data_o  = (rb_i  == '0) ? '0 : regs_q[rb_i];
  assign dbg_data_o = (dbg_i == '0) ? '0 : regs_q[dbg_i];

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0 && !(seed_we_i && seed_idx_i == wa_i))
      |=> regs_q[$past(wa_i)] == $past(wd_i));

  a_r12_seed_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_we_i && seed_idx_i != '0) |=> regs_q[$past(seed_idx_i)] == $past(seed_data_i));

  a_r10_x0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == '0) |-> ra_data_o == '0);
endmodule

// File: rtl/rrc_alu.sv
module rrc_alu
  import rrc_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  logic [SHW-1:0] shamt;
  assign shamt = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_SLL:  y_o = a_i << shamt;
      ALU_SLT:  y_o = XLEN'($signed(a_i) < $signed(b_i));
      ALU_SLTU: y_o = XLEN'(a_i < b_i);
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_SRL:  y_o = a_i >> shamt;
      ALU_SRA:  y_o = XLEN'($signed(a_i) >>> shamt);
      ALU_OR:   y_o = a_i | b_i;
      ALU_AND:  y_o = a_i & b_i;
      default:  y_o = '0;
    endcase
  end

  // R6: compares yield a single bit
  always_comb begin
    if (op_i == ALU_SLT || op_i == ALU_SLTU) a_r6_cmp_bool: assert (y_o[XLEN-1:1] == '0);
  end
endmodule

// File: rtl/rrc_core.sv
module rrc_core
  import rrc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_rdata_i,
  input  logic [IDXW-1:0] dbg_idx_i,
  output logic [XLEN-1:0] dbg_data_o,
  input  logic            seed_we_i,
  input  logic [IDXW-1:0] seed_idx_i,
  input  logic [XLEN-1:0] seed_data_i
);
  logic [IDXW-1:0] rs1, rs2, rd;
  alu_op_e         op;
  logic            rf_we;
  logic [XLEN-1:0] op_a, op_b, alu_y;

  rrc_pc #(.XLEN(XLEN), .STEP(4)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_o(imem_addr_o)
  );

  rrc_decode #(.ILEN(32), .IDXW(IDXW)) u_dec (
    .instr_i(imem_rdata_i), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd),
    .op_o(op), .we_o(rf_we)
  );

  rrc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ra_i(rs1), .ra_data_o(op_a),
    .rb_i(rs2), .rb_data_o(op_b),
    .dbg_i(dbg_idx_i), .dbg_data_o(dbg_data_o),
    .we_i(rf_we), .wa_i(rd), .wd_i(alu_y),
    .seed_we_i(seed_we_i), .seed_idx_i(seed_idx_i), .seed_data_i(seed_data_i)
  );

  rrc_alu #(.XLEN(XLEN)) u_alu (
    .op_i(op), .a_i(op_a), .b_i(op_b), .y_o(alu_y)
  );

  a_r1_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> imem_addr_o == $past(imem_addr_o) + XLEN'(4));

  a_r3_opcode_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_rdata_i[6:0] != OPC_REG) |-> !rf_we);
endmodule

// File: tb/rrc_core_test.sv
module rrc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_data;
  logic        seed_we = 1'b0;
  logic [4:0]  seed_idx = '0;
  logic [31:0] seed_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] mem [128];
  assign imem_rdata = mem[imem_addr[8:2]];

  rrc_core uut (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dbg_idx_i(dbg_idx), .dbg_data_o(dbg_data),
    .seed_we_i(seed_we), .seed_idx_i(seed_idx), .seed_data_i(seed_data)
  );

  typedef struct {
    bit          sd;
    logic [4:0]  sidx;
    logic [31:0] sdat;
    logic [4:0]  chk;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] model [32];
  int          n_ins = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference semantics: returns 0 for an unsupported funct pair
  function automatic bit ref_op(logic [6:0] f7, logic [2:0] f3,
                                logic [31:0] a, logic [31:0] b, output logic [31:0] y);
    y = '0;
    if (f7 == 7'h20) begin
      if (f3 == 3'd0) begin y = a - b; return 1; end
      if (f3 == 3'd5) begin y = 32'($signed(a) >>> b[4:0]); return 1; end
      return 0;
    end
    if (f7 != 7'h00) return 0;
    case (f3)
      3'd0: y = a + b;
      3'd1: y = a << b[4:0];
      3'd2: y = {31'b0, $signed(a) < $signed(b)};
      3'd3: y = {31'b0, a < b};
      3'd4: y = a ^ b;
      3'd5: y = a >> b[4:0];
      3'd6: y = a | b;
      default: y = a & b;
    endcase
    return 1;
  endfunction

  function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  // Driver: fills the instruction array and pushes the expected outcome
  task automatic seed(logic [4:0] idx, logic [31:0] val);
    item_t it;
    mem[n_ins] = 32'h0000_0013;  // non register-register opcode: no core write
    if (idx != 0) model[idx] = val;
    it.sd = 1; it.sidx = idx; it.sdat = val;
    it.chk = idx; it.exp = model[idx];
    it.tag = (idx == 0) ? "R12/R10 seed x0" : "R12 seed";
    sb.push_back(it);
    n_ins++;
  endtask

  task automatic issue(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3,
                       logic [4:0] rd, string tag, logic [6:0] opc = 7'b0110011,
                       bit sd = 0, logic [31:0] sdat = '0);
    item_t       it;
    logic [31:0] y;
    bit          ok;
    mem[n_ins] = enc(f7, rs2, rs1, f3, rd, opc);
    ok = ref_op(f7, f3, model[rs1], model[rs2], y);
    if (opc == 7'b0110011 && ok && rd != 0) model[rd] = y;
    if (sd && rd != 0) model[rd] = sdat;
    it.sd = sd; it.sidx = rd; it.sdat = sdat;
    it.chk = rd; it.exp = model[rd]; it.tag = tag;
    sb.push_back(it);
    n_ins++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;

    seed(5'd1, 32'h0000_0007);
    seed(5'd2, 32'hFFFF_FFF9);
    seed(5'd3, 32'h8000_0000);
    seed(5'd4, 32'h7FFF_FFFF);
    seed(5'd5, 32'h0000_0023);
    seed(5'd6, 32'h1234_5678);
    seed(5'd7, 32'h0F0F_00FF);
    seed(5'd8, 32'hFFFF_FFFF);
    seed(5'd9, 32'h0000_0001);
    seed(5'd0, 32'h0000_DEAD);

    issue(7'h00, 5'd2, 5'd1, 3'd0, 5'd10, "R5 add to zero");
    issue(7'h00, 5'd9, 5'd4, 3'd0, 5'd11, "R5 add overflow wraps");
    issue(7'h20, 5'd2, 5'd1, 3'd0, 5'd12, "R5 sub");
    issue(7'h20, 5'd9, 5'd3, 3'd0, 5'd13, "R5 sub underflow wraps");
    issue(7'h00, 5'd1, 5'd2, 3'd2, 5'd14, "R6 slt negative<positive");
    issue(7'h00, 5'd1, 5'd2, 3'd3, 5'd15, "R6 sltu large>small");
    issue(7'h00, 5'd4, 5'd3, 3'd2, 5'd16, "R6 slt min<max");
    issue(7'h00, 5'd1, 5'd1, 3'd2, 5'd16, "R6 slt equal gives 0");
    issue(7'h00, 5'd7, 5'd6, 3'd4, 5'd17, "R7 xor");
    issue(7'h00, 5'd7, 5'd6, 3'd6, 5'd18, "R7 or");
    issue(7'h00, 5'd7, 5'd6, 3'd7, 5'd19, "R7 and");
    issue(7'h00, 5'd5, 5'd6, 3'd1, 5'd20, "R8 sll low 5 bits");
    issue(7'h00, 5'd5, 5'd3, 3'd5, 5'd21, "R8 srl");
    issue(7'h20, 5'd5, 5'd3, 3'd5, 5'd22, "R8 sra sign fill");
    issue(7'h20, 5'd9, 5'd2, 3'd5, 5'd23, "R8 sra negative");
    issue(7'h00, 5'd12, 5'd12, 3'd0, 5'd24, "R2 write");
    issue(7'h20, 5'd1, 5'd24, 3'd0, 5'd25, "R2 back-to-back read");
    issue(7'h00, 5'd7, 5'd6, 3'd0, 5'd0, "R10 write x0 discarded");
    issue(7'h00, 5'd6, 5'd0, 3'd0, 5'd26, "R10 x0 operand reads 0");
    issue(7'h00, 5'd7, 5'd1, 3'd0, 5'd6, "R3 other opcode no write", 7'b0010011);
    issue(7'h00, 5'd7, 5'd1, 3'd0, 5'd6, "R3 opcode 0 no write", 7'b0000000);
    issue(7'h01, 5'd7, 5'd1, 3'd0, 5'd6, "R9 funct7 0000001 no write");
    issue(7'h20, 5'd7, 5'd1, 3'd1, 5'd7, "R9 alt funct7 on sll no write");
    issue(7'h20, 5'd7, 5'd1, 3'd4, 5'd7, "R9 alt funct7 on xor no write");
    issue(7'h00, 5'd2, 5'd4, 3'd0, 5'd8, "R12 seed beats core write", 7'b0110011, 1'b1, 32'h0000_0055);
    issue(7'h00, 5'd8, 5'd26, 3'd0, 5'd27, "R4 fields after priority");

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset address", imem_addr, 32'h0);
    for (int r = 0; r < 32; r += 7) begin
      dbg_idx = 5'(r);
      #1;
      check(dbg_data == 32'h0, "R11 reset clears registers", dbg_data, 32'h0);
    end
    rst_n = 1'b1;

    // Monitor: pop expectations as the core retires each cycle
    for (int k = 0; sb.size() > 0; k++) begin
      item_t it;
      it = sb.pop_front();
      seed_we   = it.sd;
      seed_idx  = it.sidx;
      seed_data = it.sdat;
      #1;
      check(imem_addr == 32'(k * 4), "R1 address step", imem_addr, 32'(k * 4));
      @(posedge clk);
      @(negedge clk);
      seed_we = 1'b0;
      dbg_idx = it.chk;
      #1;
      check(dbg_data === it.exp, {it.tag, " (R13 debug read)"}, dbg_data, it.exp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule